// File: doc/BRIEF.md
# Power-up strap capture and clock output release

This block handles a group of pads that serve two purposes. While the supply is still coming up, each pad is an input and its level selects a configuration option. When the power-good indication first goes high, the level on every pad is stored in a register. A pad that nothing drives reads as 1, because of its pull-up. The pads then become outputs held low. When a power-up timer ends, each pad starts forwarding its clock.

The captured values stay fixed until a full synchronous reset, whatever later happens on the pads or on power-good. The gate that releases each clock opens only while that source clock is low, so the first high pulse on the pad has full width. The timer length is a parameter counted in system clock cycles. Its default is sized for about 3 ms at 100 MHz.

Top module: `pwrup_strap_release`

## Requirements
- R1: While `rst_n` is sampled low, the next edge clears `strap_q`, `straps_valid` and `pin_oe` to 0 and forces `clk_out` to all zeros.
- R2: On the first rising clock edge after reset at which `pwr_good` is high, having been low at the previous edge or in reset, `strap_q[i]` takes the pad level of bit i. From that edge on, `straps_valid` and `pin_oe` read 1.
- R3: A pad marked undriven (`pin_float[i]` = 1) is captured as 1, whatever `pin_in[i]` shows.
- R4: After capture, changes on `pin_in`, `pin_float` or `pwr_good` leave `strap_q`, `straps_valid` and `pin_oe` unchanged.
- R5: For the first TIMER_CYCLES edges after the capture edge, `clk_out` stays all zeros while `pin_oe` is 1.
- R6: After the timer ends, each `clk_out[i]` is enabled at an edge where `clk_src[i]` is low. From then on it equals `clk_src[i]`, so every high pulse, including the first, is a full source high phase.
- R7: A reset after a capture returns the block to the input phase, and a new power-good rise captures the new pad levels.
- R8: While `pwr_good` stays low after reset, `pin_oe`, `straps_valid` and `clk_out` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply valid indication |
| pin_in | input | NUM_PINS | Level seen on each pad while it acts as an input |
| pin_float | input | NUM_PINS | 1 where the pad is undriven (pull-up gives 1) |
| clk_src | input | NUM_PINS | Clock to forward on each pad, synchronous to clk |
| strap_q | output | NUM_PINS | Captured configuration values |
| straps_valid | output | 1 | Sticky flag: straps have been captured |
| pin_oe | output | 1 | Pad output enable (0 = input, 1 = driving) |
| clk_out | output | NUM_PINS | Gated clocks driven onto the pads |

## Verification
Two situations are hard to reach from the ports. One is a source clock that is already high when the timer ends. The other is a change on the pads or on power-good after capture. To reach the first, each pad gets a source clock with its own half-period of 1 to 5 cycles, so the timer ends at a different phase on every pad. The bench then measures every output high pulse against that half-period. To reach the second, the bench inverts the pads, clears the undriven flags and pulses power-good during the timer window, while checking the stored values on every cycle. Two sweeps run: one over all 32 pad patterns and one over all 32 undriven masks.

// File: rtl/strap_pkg.sv
// Shared types for the power-up strap and clock release logic.
package strap_pkg;
    // Pad phase: input (straps sampled), driven low (timer running), clocks released
    typedef enum logic [1:0] {
        PH_INPUT    = 2'd0,
        PH_HOLD_LOW = 2'd1,
        PH_RUN      = 2'd2
    } phase_e;
endpackage

// File: rtl/strap_capture.sv
// Captures the pad levels once, on the first power-good rise after reset.
// Assumes pwr_good is already synchronous to clk. An undriven pad reads as 1.
module strap_capture #(
    parameter int NUM_PINS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_good,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_float,
    output logic [NUM_PINS-1:0] strap_q,
    output logic                captured,
    output logic                capture_pulse
);
    logic                pg_q;
    logic [NUM_PINS-1:0] pad_level;

    // Effective pad level including the pull-up on undriven pads
    assign pad_level     = pin_in | pin_float;
    assign capture_pulse = pwr_good & ~pg_q & ~captured;

    // Power-good history used to find the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= pwr_good;
    end

    // One-time strap capture with a sticky done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q  <= '0;
            captured <= 1'b0;
        end else if (capture_pulse) begin
            strap_q  <= pad_level;
            captured <= 1'b1;
        end
    end

    // R4: once captured, the values never move
    a_r4_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && $past(captured)) |-> $stable(strap_q));
    // R4: the sticky flag never drops outside reset
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        captured |=> captured);
endmodule

// File: rtl/release_timer.sv
// Sequences the pad phase: input, then held low for TIMER_CYCLES, then run.
// Assumes start pulses for a single cycle, and only in the input phase.
module release_timer
    import strap_pkg::*;
#(
    parameter int TIMER_CYCLES = 300000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase
);
    localparam int CW = $clog2(TIMER_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMER_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Phase sequencing and power-up timer count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_INPUT;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_INPUT: if (start) begin
                    phase <= PH_HOLD_LOW;
                    cnt   <= '0;
                end
                PH_HOLD_LOW: if (cnt == LAST) phase <= PH_RUN;
                             else             cnt   <= cnt + 1'b1;
                PH_RUN:      phase <= PH_RUN;
                default:     phase <= PH_INPUT;
            endcase
        end
    end

    // R5: the run phase is never left outside reset
    a_r5_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |=> (phase == PH_RUN));
    // R5: the count stays inside the timer window
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD_LOW) |-> (cnt <= LAST));
    // R8: the input phase is left only on a start
    a_r8_stay_input: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INPUT && !start) |=> (phase == PH_INPUT));
endmodule

// File: rtl/clk_release_gate.sv
// Per-pad clock gate. It opens only at an edge where the source clock is
// sampled low, so the first output pulse is a full high phase.
// Assumes each clk_src bit changes only on clk rising edges.
module clk_release_gate #(
    parameter int NUM_PINS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [NUM_PINS-1:0] clk_src,
    output logic [NUM_PINS-1:0] clk_out
);
    logic [NUM_PINS-1:0] en_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        // Enable set during the source low phase once release is granted
        always_ff @(posedge clk) begin
            if (!rst_n)                     en_q[g] <= 1'b0;
            else if (run && !clk_src[g])    en_q[g] <= 1'b1;
        end

        assign clk_out[g] = clk_src[g] & en_q[g];

        // R6: the enable opens only while the source is low
        a_r6_low_phase_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_q[g]) |-> !$past(clk_src[g]));
        // R6: once open, the gate stays open
        a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            en_q[g] |=> en_q[g]);
    end
endmodule

// File: rtl/pwrup_strap_release.sv
// Top level: dual-purpose pads that are straps at power-up and clock outputs
// afterwards. Pad tri-state is represented only by pin_oe.
// Assumes all inputs are synchronous to clk.
module pwrup_strap_release
    import strap_pkg::*;
#(
    parameter int NUM_PINS     = 5,
    parameter int TIMER_CYCLES = 300000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_good,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_float,
    input  logic [NUM_PINS-1:0] clk_src,
    output logic [NUM_PINS-1:0] strap_q,
    output logic                straps_valid,
    output logic                pin_oe,
    output logic [NUM_PINS-1:0] clk_out
);
    phase_e phase;
    logic   capture_pulse;
    logic   run;

    strap_capture #(.NUM_PINS(NUM_PINS)) capture_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good      (pwr_good),
        .pin_in        (pin_in),
        .pin_float     (pin_float),
        .strap_q       (strap_q),
        .captured      (straps_valid),
        .capture_pulse (capture_pulse)
    );

    release_timer #(.TIMER_CYCLES(TIMER_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (capture_pulse),
        .phase (phase)
    );

    // Pads drive once the straps are taken; clocks only in the run phase
    assign pin_oe = (phase != PH_INPUT);
    assign run    = (phase == PH_RUN);

    clk_release_gate #(.NUM_PINS(NUM_PINS)) gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clk_src (clk_src),
        .clk_out (clk_out)
    );

    // R5: pads are driven low while the timer runs
    a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD_LOW) |-> (clk_out == '0));
    // R8: no drive and no clocks before capture
    a_r8_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !straps_valid |-> (!pin_oe && clk_out == '0));
    // R2: output enable and valid flag rise together
    a_r2_oe_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe == straps_valid);
endmodule

// File: tb/pwrup_strap_release_tb_top.sv
module pwrup_strap_release_tb_top;
    localparam int N = 5;
    localparam int T = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwr_good = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_float = '0;
    logic [N-1:0] clk_src = '0;
    logic [N-1:0] strap_q;
    logic         straps_valid;
    logic         pin_oe;
    logic [N-1:0] clk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwrup_strap_release #(.NUM_PINS(N), .TIMER_CYCLES(T)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pin_in(pin_in),
        .pin_float(pin_float), .clk_src(clk_src), .strap_q(strap_q),
        .straps_valid(straps_valid), .pin_oe(pin_oe), .clk_out(clk_out)
    );

    // Source clocks: pad i has a half-period of i+1 cycles
    logic [2:0] div_cnt [N];
    initial for (int i = 0; i < N; i++) div_cnt[i] = '0;
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (div_cnt[i] == 3'(i)) begin
                div_cnt[i] <= '0;
                clk_src[i] <= ~clk_src[i];
            end else begin
                div_cnt[i] <= div_cnt[i] + 3'd1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [N-1:0] pins, input logic [N-1:0] flt);
        logic [N-1:0] exp_strap;
        int run_len [N];
        int pulses  [N];
        exp_strap = pins | flt;
        rst_n = 1'b0;
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        chk(strap_q == '0 && !straps_valid && !pin_oe && clk_out == '0,
            "R1 reset state", {strap_q, straps_valid, pin_oe}, 0);
        rst_n = 1'b1;
        pin_in = pins;
        pin_float = flt;
        repeat (5) begin
            @(negedge clk);
            chk(!pin_oe && !straps_valid && clk_out == '0, "R8 idle before power good",
                {pin_oe, straps_valid, clk_out}, 0);
        end
        pwr_good = 1'b1;
        @(negedge clk);
        chk(strap_q == exp_strap, "R2 R3 R7 captured straps", strap_q, exp_strap);
        chk(straps_valid && pin_oe, "R2 valid and oe", {straps_valid, pin_oe}, 3);
        // Disturb pads and power good during the timer window
        pin_in = ~pins;
        pin_float = '0;
        for (int c = 0; c < T; c++) begin
            if (c == 2) pwr_good = 1'b0;
            if (c == 4) pwr_good = 1'b1;
            chk(clk_out == '0 && pin_oe, "R5 held low during timer", clk_out, 0);
            chk(strap_q == exp_strap && straps_valid, "R4 straps frozen", strap_q, exp_strap);
            @(negedge clk);
        end
        for (int i = 0; i < N; i++) begin
            run_len[i] = 0;
            pulses[i] = 0;
        end
        for (int c = 0; c < 60; c++) begin
            for (int i = 0; i < N; i++) begin
                if (clk_out[i]) run_len[i]++;
                else begin
                    if (run_len[i] > 0) begin
                        chk(run_len[i] == i + 1, "R6 full-width pulse", run_len[i], i + 1);
                        pulses[i]++;
                    end
                    run_len[i] = 0;
                end
            end
            if (c >= 30)
                chk(clk_out == clk_src, "R6 output follows source", clk_out, clk_src);
            @(negedge clk);
        end
        for (int i = 0; i < N; i++)
            chk(pulses[i] > 0, "R6 clock released", pulses[i], 1);
        chk(strap_q == exp_strap && pin_oe, "R4 straps still frozen", strap_q, exp_strap);
    endtask

    initial begin
        for (int p = 0; p < 32; p++) run_case(5'(p), '0);
        for (int m = 0; m < 32; m++) run_case('0, 5'(m));
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule